// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This bridge sits between one 32-bit bus master and one memory or peripheral slave. Both sides use a plain request/ready handshake that carries an address, a write enable, write data and read data. Most accesses are forwarded unchanged as one slave transaction. An access whose address falls inside one of two 32 MB alias windows is instead treated as an operation on a single bit of a word in the matching 1 MB bit-addressable region. Each bit of that region has its own 32-bit alias word.

A store to an alias word becomes a locked read-modify-write of the containing word. The bridge reads the word, replaces the one selected bit with bit 0 of the store data, and writes the word back. The downstream lock stays high throughout, so no other agent can get in between the read and the write. A load from an alias word reads the containing word once and returns the selected bit in bit 0 of the response.

Software can therefore set or clear a flag with a single store, without a separate read, mask and write.

Top module: `bitband_bridge`

## Requirements
- R1: An access outside both alias windows produces exactly one slave transaction. Its address, write enable and write data equal the master's. The lock stays low. For a load, the response data equals the slave's read data.
- R2: In the low window (alias base 0x22000000, region base 0x20000000), the alias address is decoded as follows. Bits [24:5] are the byte offset and bits [4:2] are the bit index. The target word is the region base plus the byte offset with its two low bits cleared. The bit position is 8 × (byte offset mod 4) + bit index. For example, 0x2200004C selects bit 19 of word 0x20000000.
- R3: The high window (alias base 0x42000000, region base 0x40000000) decodes the same way. For example, 0x420020F8 selects bit 30 of word 0x40000104.
- R4: A store with data bit 0 = 1 to an alias word produces a slave read and then a slave write of the target word. The written word equals the word that was read with the selected bit set.
- R5: A store with data bit 0 = 0 to an alias word writes back the word that was read with the selected bit cleared. All other bits are unchanged.
- R6: On an alias store, data bits 31:1 have no effect on the word written back.
- R7: A load from an alias word produces exactly one slave read and no slave write. The response carries the selected bit in bit 0, and bits 31:1 are zero.
- R8: During an alias store, the lock is high on both the read and the write transactions and does not drop between them. The master's ready is not given before the write-back has completed.
- R9: A direct access to an address inside a bit-addressable region, as opposed to its alias window, is forwarded unchanged, exactly as in R1.
- R10: Address bits [1:0] of an alias access have no effect on the target word or the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master request, held until m_ready |
| m_addr | input | 32 | Master byte address |
| m_we | input | 1 | Master write enable |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | One-cycle completion pulse to the master |
| m_rdata | output | 32 | Response data, valid with m_ready |
| s_req | output | 1 | Slave request, held until s_ready |
| s_addr | output | 32 | Slave word address |
| s_we | output | 1 | Slave write enable |
| s_wdata | output | 32 | Slave write data |
| s_lock | output | 1 | Keeps the slave bus locked across a read-modify-write |
| s_ready | input | 1 | Slave completion pulse |
| s_rdata | input | 32 | Slave read data, valid with s_ready |

## Verification
Two things can land in the same cycle: the completion of the locked read and the launch of the write-back. With a zero-wait slave, the captured read word, the bit merge and the new write request all fall on one clock edge, and the lock must carry over that edge without a gap. The bench runs alias stores against a zero-wait slave and against slaves with several wait states. It logs every slave acceptance together with its lock level, counts lock falling edges, and judges each store by its exact sequence: one locked read, then one locked write of the merged word, then the master's ready.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int unsigned BB_AW = 32;
    localparam int unsigned BB_DW = 32;
    localparam int unsigned BB_BIT_W = $clog2(BB_DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_ALIAS_RD,
        ST_ALIAS_WR,
        ST_DONE
    } bb_state_e;

    typedef struct packed {
        bb_state_e            st;
        logic                 is_alias;
        logic                 we;
        logic [BB_AW-1:0]     addr;
        logic [BB_DW-1:0]     wdata;
        logic [BB_BIT_W-1:0]  bitpos;
        logic [BB_DW-1:0]     rdata;
    } bb_regs_t;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode #(
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter int unsigned NWIN     = 2,
    parameter int unsigned SPAN_W   = 25,
    parameter logic [NWIN*AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN*AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [AW-1:0]          addr,
    output logic                   hit,
    output logic [AW-1:0]          word_addr,
    output logic [$clog2(DW)-1:0]  bitpos
);
    localparam int unsigned BIT_W    = $clog2(DW);
    localparam int unsigned LANE_LSB = $clog2(DW / 8);
    localparam int unsigned OFF_W    = SPAN_W - BIT_W;
    localparam int unsigned TAG_W    = AW - SPAN_W;

    logic [NWIN-1:0]   hit_w;
    logic [AW-1:0]     word_w [NWIN];
    logic [OFF_W-1:0]  word_off;

    // aligned byte offset of the containing word inside the bit region
    assign word_off = {addr[SPAN_W-1:LANE_LSB+BIT_W], {LANE_LSB{1'b0}}};
    // position = 8*(byte offset mod bytes-per-word) + bit index
    assign bitpos   = addr[LANE_LSB+BIT_W-1:LANE_LSB];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign hit_w[w]  = (addr[AW-1:SPAN_W] == ALIAS_BASES[w*AW+SPAN_W +: TAG_W]);
        assign word_w[w] = REGION_BASES[w*AW +: AW] + AW'(word_off);
    end

    always_comb begin
        hit       = 1'b0;
        word_addr = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_w[w]) begin
                hit       = 1'b1;
                word_addr = word_w[w];
            end
        end
    end
endmodule

// File: rtl/bb_bit_op.sv
module bb_bit_op #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0]          word_in,
    input  logic [$clog2(DW)-1:0]  bitpos,
    input  logic                   new_val,
    output logic [DW-1:0]          word_out,
    output logic                   bit_out
);
    logic [DW-1:0] sel_mask;

    assign sel_mask = DW'(1) << bitpos;
    assign word_out = (word_in & ~sel_mask) | (new_val ? sel_mask : '0);
    assign bit_out  = word_in[bitpos];
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic [BB_AW-1:0]  m_addr,
    input  logic              m_we,
    input  logic [BB_DW-1:0]  m_wdata,
    output logic              m_ready,
    output logic [BB_DW-1:0]  m_rdata,
    output logic              s_req,
    output logic [BB_AW-1:0]  s_addr,
    output logic              s_we,
    output logic [BB_DW-1:0]  s_wdata,
    output logic              s_lock,
    input  logic              s_ready,
    input  logic [BB_DW-1:0]  s_rdata
);
    bb_regs_t r_d, r_q;

    logic                 dec_hit;
    logic [BB_AW-1:0]     dec_word;
    logic [BB_BIT_W-1:0]  dec_bitpos;
    logic [BB_DW-1:0]     merged;
    logic                 picked;

    bb_alias_decode #(
        .AW(BB_AW),
        .DW(BB_DW)
    ) u_dec (
        .addr      (m_addr),
        .hit       (dec_hit),
        .word_addr (dec_word),
        .bitpos    (dec_bitpos)
    );

    bb_bit_op #(
        .DW(BB_DW)
    ) u_bit (
        .word_in  (s_rdata),
        .bitpos   (r_q.bitpos),
        .new_val  (r_q.wdata[0]),
        .word_out (merged),
        .bit_out  (picked)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (m_req) begin
                    r_d.we       = m_we;
                    r_d.wdata    = m_wdata;
                    r_d.is_alias = dec_hit;
                    r_d.bitpos   = dec_bitpos;
                    r_d.addr     = dec_hit ? dec_word : m_addr;
                    r_d.st       = dec_hit ? ST_ALIAS_RD : ST_PASS;
                end
            end
            ST_PASS: begin
                if (s_ready) begin
                    r_d.rdata = r_q.we ? '0 : s_rdata;
                    r_d.st    = ST_DONE;
                end
            end
            ST_ALIAS_RD: begin
                if (s_ready) begin
                    if (r_q.we) begin
                        r_d.wdata = merged;
                        r_d.st    = ST_ALIAS_WR;
                    end else begin
                        r_d.rdata = {{(BB_DW-1){1'b0}}, picked};
                        r_d.st    = ST_DONE;
                    end
                end
            end
            ST_ALIAS_WR: begin
                if (s_ready) begin
                    r_d.rdata = '0;
                    r_d.st    = ST_DONE;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign s_req   = (r_q.st == ST_PASS) || (r_q.st == ST_ALIAS_RD) || (r_q.st == ST_ALIAS_WR);
    assign s_we    = (r_q.st == ST_PASS) ? r_q.we : (r_q.st == ST_ALIAS_WR);
    assign s_addr  = r_q.addr;
    assign s_wdata = r_q.wdata;
    assign s_lock  = (r_q.st == ST_ALIAS_RD) || (r_q.st == ST_ALIAS_WR);
    assign m_ready = (r_q.st == ST_DONE);
    assign m_rdata = r_q.rdata;

    // lock carries straight from the read into the write-back
    p_lock_into_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lock && !s_we && s_ready && r_q.we) |=> (s_lock && s_req && s_we));

    // master only released once the write-back is acknowledged
    p_ready_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lock && s_we && s_ready) |=> m_ready);

    // alias load answers with a single bit
    p_alias_rd_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ready && r_q.is_alias && !r_q.we) |-> (m_rdata[BB_DW-1:1] == '0));

    // forwarded traffic never locks the bus
    p_pass_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !r_q.is_alias) |-> !s_lock);

    // slave-side request held steady while waiting
    p_req_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !s_ready) |=> (s_req && $stable(s_addr) && $stable(s_we)));
endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0;
    logic [31:0] m_addr = '0;
    logic        m_we = 1'b0;
    logic [31:0] m_wdata = '0;
    logic        m_ready;
    logic [31:0] m_rdata;
    logic        s_req;
    logic [31:0] s_addr;
    logic        s_we;
    logic [31:0] s_wdata;
    logic        s_lock;
    logic        s_ready = 1'b0;
    logic [31:0] s_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bitband_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata),
        .s_req(s_req), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata),
        .s_lock(s_lock), .s_ready(s_ready), .s_rdata(s_rdata)
    );

    // slave model with adjustable wait states and an acceptance log
    logic [31:0] mem [64];
    int          waits = 0;
    int          wcnt = 0;
    int          acc_n = 0;
    logic [31:0] acc_addr  [256];
    logic [31:0] acc_data  [256];
    logic        acc_we    [256];
    logic        acc_lock  [256];
    int          lock_falls = 0;
    logic        lock_prev = 1'b0;

    function automatic int midx(input logic [31:0] a);
        return {26'd0, a[30], a[6:2]};
    endfunction

    initial for (int i = 0; i < 64; i++) mem[i] = '0;

    always @(posedge clk) begin
        lock_prev <= s_lock;
        if (lock_prev && !s_lock) lock_falls <= lock_falls + 1;
        if (s_ready) begin
            s_ready <= 1'b0;
        end else if (s_req) begin
            if (wcnt >= waits) begin
                wcnt    <= 0;
                s_ready <= 1'b1;
                acc_addr[acc_n % 256] <= s_addr;
                acc_we[acc_n % 256]   <= s_we;
                acc_lock[acc_n % 256] <= s_lock;
                if (s_we) begin
                    mem[midx(s_addr)]     <= s_wdata;
                    acc_data[acc_n % 256] <= s_wdata;
                end else begin
                    s_rdata               <= mem[midx(s_addr)];
                    acc_data[acc_n % 256] <= mem[midx(s_addr)];
                end
                acc_n <= acc_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one master access; returns response data and slave-log start index
    task automatic access(input logic [31:0] a, input bit we, input logic [31:0] d,
                          output logic [31:0] rd, output int first, output int falls0,
                          output int writes_at_ready);
        int guard;
        @(negedge clk);
        first  = acc_n;
        falls0 = lock_falls;
        m_addr = a; m_we = we; m_wdata = d; m_req = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!m_ready && guard < 200);
        writes_at_ready = 0;
        for (int i = first; i < acc_n; i++) if (acc_we[i % 256]) writes_at_ready++;
        rd = m_rdata;
        m_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!m_ready, "R1 reset ready", 32'(m_ready), 0);
        chk(!s_req && !s_lock, "R1 reset slave side", {30'd0, s_req, s_lock}, 0);
    endtask

    task automatic t_pass;
        logic [31:0] rd; int f, l, w;
        waits = 1;
        access(32'h3000_0010, 1'b1, 32'hDEAD_BEEF, rd, f, l, w);
        chk(acc_n - f == 1, "R1 pass write count", 32'(acc_n - f), 1);
        chk(acc_addr[f] == 32'h3000_0010 && acc_we[f], "R1 pass write addr", acc_addr[f], 32'h3000_0010);
        chk(acc_data[f] == 32'hDEAD_BEEF && !acc_lock[f], "R1 pass write data/lock", acc_data[f], 32'hDEAD_BEEF);
        access(32'h3000_0010, 1'b0, 32'h0, rd, f, l, w);
        chk(rd == 32'hDEAD_BEEF && acc_n - f == 1, "R1 pass read data", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_direct;
        logic [31:0] rd; int f, l, w;
        waits = 0;
        access(32'h2000_0000, 1'b1, 32'hA5A5_0F0F, rd, f, l, w);
        chk(acc_n - f == 1 && acc_addr[f] == 32'h2000_0000, "R9 direct region write", acc_addr[f], 32'h2000_0000);
        chk(acc_data[f] == 32'hA5A5_0F0F && !acc_lock[f], "R9 direct data unchanged", acc_data[f], 32'hA5A5_0F0F);
        access(32'h4000_0104, 1'b1, 32'h0, rd, f, l, w);
        chk(acc_n - f == 1 && acc_addr[f] == 32'h4000_0104, "R9 direct high region", acc_addr[f], 32'h4000_0104);
    endtask

    // zero-wait slave: read completion and write launch on the same edge
    task automatic t_alias_set;
        logic [31:0] rd; int f, l, w;
        waits = 0;
        access(32'h2200_004C, 1'b1, 32'h1, rd, f, l, w);
        chk(acc_n - f == 2, "R4 two slave transactions", 32'(acc_n - f), 2);
        chk(!acc_we[f] && acc_addr[f] == 32'h2000_0000, "R2 read of target word", acc_addr[f], 32'h2000_0000);
        chk(acc_we[f+1] && acc_addr[f+1] == 32'h2000_0000, "R2 write of target word", acc_addr[f+1], 32'h2000_0000);
        chk(acc_data[f+1] == 32'hA5AD_0F0F, "R4 bit 19 set", acc_data[f+1], 32'hA5AD_0F0F);
        chk(acc_lock[f] && acc_lock[f+1] && lock_falls - l == 1, "R8 lock continuous",
            32'(lock_falls - l), 1);
        chk(w == 1, "R8 ready after write-back", 32'(w), 1);
    endtask

    task automatic t_alias_clear;
        logic [31:0] rd; int f, l, w;
        waits = 3;
        access(32'h2200_0020, 1'b1, 32'hFFFF_FFFE, rd, f, l, w);
        chk(acc_n - f == 2 && acc_data[f+1] == 32'hA5AD_0E0F, "R5 R6 bit 8 cleared, upper data ignored",
            acc_data[f+1], 32'hA5AD_0E0F);
        chk(lock_falls - l == 1 && w == 1, "R8 lock with wait states", 32'(lock_falls - l), 1);
        access(32'h2200_0023, 1'b1, 32'h0000_0003, rd, f, l, w);
        chk(acc_addr[f+1] == 32'h2000_0000 && acc_data[f+1] == 32'hA5AD_0F0F,
            "R10 low address bits ignored", acc_data[f+1], 32'hA5AD_0F0F);
    endtask

    task automatic t_alias_read;
        logic [31:0] rd; int f, l, w;
        waits = 2;
        access(32'h2200_004C, 1'b0, 32'hFFFF_FFFF, rd, f, l, w);
        chk(rd == 32'h1, "R7 read bit 19", rd, 32'h1);
        chk(acc_n - f == 1 && !acc_we[f] && acc_addr[f] == 32'h2000_0000, "R7 single read only",
            32'(acc_n - f), 1);
        access(32'h2200_0010, 1'b0, 32'h0, rd, f, l, w);
        chk(rd == 32'h0, "R7 read clear bit 4", rd, 32'h0);
        access(32'h2200_0006, 1'b0, 32'h0, rd, f, l, w);
        chk(rd == 32'h1, "R10 R7 read bit 1 with low bits", rd, 32'h1);
    endtask

    task automatic t_high_window;
        logic [31:0] rd; int f, l, w;
        waits = 1;
        access(32'h4200_20F8, 1'b1, 32'h1, rd, f, l, w);
        chk(acc_n - f == 2 && acc_addr[f] == 32'h4000_0104, "R3 high window word", acc_addr[f], 32'h4000_0104);
        chk(acc_data[f+1] == 32'h4000_0000, "R3 bit 30 set", acc_data[f+1], 32'h4000_0000);
        access(32'h4200_20F8, 1'b0, 32'h0, rd, f, l, w);
        chk(rd == 32'h1, "R3 high window read", rd, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_pass();
        t_direct();
        t_alias_set();
        t_alias_clear();
        t_alias_read();
        t_high_window();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule